// File: doc/BRIEF.md
# Doorbell and Message Register Unit

This block sits between a remote bus master (the host side) and the local processor complex, and lets each side signal the other through registers. Each side has its own simple register port: a write strobe, a read strobe, a word address and data. The host rings the inbound doorbell by setting bits in it, and the local side acknowledges by clearing those bits. The local side rings the outbound doorbell in the same way, and only the host can clear it. Two inbound and two outbound message words carry a 32-bit value each. Writing one raises an interrupt on the receiving side, and that interrupt stays pending until the receiver reads the word or clears its status bit.

A second mode lets two local processors interrupt each other. In this mode each processor owns a 32-bit doorbell that the other processor sets and that the owner clears. While this mode is enabled, the standard doorbells and message words are frozen and their interrupts are held low. While it is disabled, the processor-to-processor doorbells are frozen and their interrupts are held low.

Top module: `msg_doorbell_unit`

## Requirements
- R1: After reset every register reads zero and all four interrupt outputs are low.
- R2: A host write to host address 0 ORs the write data into the inbound doorbell. local_irq is high from the next cycle while any inbound doorbell bit is set and source 0 is unmasked. No other access sets an inbound doorbell bit.
- R3: A local write to local address 0 clears the inbound doorbell bits written as one. Bits written as zero are unchanged. When a bit is set by the host and cleared by the local side in the same cycle, the clear wins.
- R4: A local write to local address 1 ORs the data into the outbound doorbell, and host_irq follows. Only a host write to host address 1 clears outbound doorbell bits, one for one. host_irq stays high while any outbound doorbell bit remains set and unmasked.
- R5: A host write to host address 2+i (i = 0 or 1) stores inbound message i and sets its pending flag. The flag raises local_irq. It is cleared by a local read of local address 2+i, or by a local write to local address 6 with data bit 1+i set. A new write in the same cycle as a clear leaves the flag set.
- R6: A local write to local address 4+i stores outbound message i and sets its pending flag. The flag raises host_irq. It is cleared by a host read of host address 4+i, or by a host write to host address 6 with data bit 1+i set. A new write in the same cycle as a clear leaves the flag set.
- R7: Each interrupt source has its own mask bit, where 1 blocks the source: bit 0 for the doorbell, bit 1 for message 0 and bit 2 for message 1. The host mask is at host address 7. The local mask is bits 2:0 of local address 7.
- R8: Status reads return {message 1 pending, message 0 pending, doorbell nonzero} in bits 2:0. Host address 6 reports the outbound side and local address 6 reports the inbound side. Local address 7 reads {mode, mask} in bits 3:0.
- R9: Bit 3 of local address 7 enables the processor-to-processor mode. Local addresses 8 and 9 set and clear doorbell 1, which drives cpu1_irq. Local addresses 10 and 11 set and clear doorbell 0, which drives cpu0_irq. Local addresses 12 and 13 read doorbells 1 and 0.
- R10: While the mode bit is set, host_irq and local_irq are low, and writes and clearing reads to the standard registers and the host mask have no effect. While it is clear, cpu0_irq and cpu1_irq are low and writes to local addresses 8 to 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (clears message pending) |
| h_addr | input | 3 | Host word address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, combinational from address |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe (clears message pending) |
| l_addr | input | 4 | Local word address |
| l_wdata | input | DW | Local write data |
| l_rdata | output | DW | Local read data, combinational from address |
| host_irq | output | 1 | Interrupt to the host |
| local_irq | output | 1 | Interrupt to the local processor |
| cpu0_irq | output | 1 | Processor-to-processor interrupt to processor 0 |
| cpu1_irq | output | 1 | Processor-to-processor interrupt to processor 1 |

## Verification
The hardest situations to reach are the same-cycle collisions between the two ports. These are a host set meeting a local clear of the same doorbell bit, and a new message write landing in the cycle in which the receiver's read clears the pending flag. The stimulus drives both ports in one cycle for these cases. A second hard case is the mode switch with interrupts already pending: the stimulus leaves an inbound doorbell bit set, enters the processor-to-processor mode, shows local_irq dropping and the frozen registers ignoring writes, and then leaves the mode to show the interrupt returning.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int HADDR_W = 3;
  localparam int LADDR_W = 4;
  localparam int N_MSG   = 2;
  localparam int N_SRC   = N_MSG + 1;

  // host side word addresses
  localparam logic [HADDR_W-1:0] HA_IDB  = 3'd0;
  localparam logic [HADDR_W-1:0] HA_ODB  = 3'd1;
  localparam logic [HADDR_W-1:0] HA_IMSG = 3'd2;
  localparam logic [HADDR_W-1:0] HA_OMSG = 3'd4;
  localparam logic [HADDR_W-1:0] HA_STAT = 3'd6;
  localparam logic [HADDR_W-1:0] HA_MASK = 3'd7;

  // local side word addresses
  localparam logic [LADDR_W-1:0] LA_IDB   = 4'd0;
  localparam logic [LADDR_W-1:0] LA_ODB   = 4'd1;
  localparam logic [LADDR_W-1:0] LA_IMSG  = 4'd2;
  localparam logic [LADDR_W-1:0] LA_OMSG  = 4'd4;
  localparam logic [LADDR_W-1:0] LA_STAT  = 4'd6;
  localparam logic [LADDR_W-1:0] LA_CTRL  = 4'd7;
  localparam logic [LADDR_W-1:0] LA_X1SET = 4'd8;
  localparam logic [LADDR_W-1:0] LA_X1CLR = 4'd9;
  localparam logic [LADDR_W-1:0] LA_X0SET = 4'd10;
  localparam logic [LADDR_W-1:0] LA_X0CLR = 4'd11;
  localparam logic [LADDR_W-1:0] LA_X1RD  = 4'd12;
  localparam logic [LADDR_W-1:0] LA_X0RD  = 4'd13;

  localparam int CTRL_MODE_BIT = 3;

  // interrupt from doorbell-nonzero plus message pending flags, mask bit 1 blocks
  function automatic logic src_irq(input logic db_nz, input logic [N_MSG-1:0] pend,
                                   input logic [N_SRC-1:0] mask);
    return |({pend, db_nz} & ~mask);
  endfunction
endpackage

// File: rtl/mdu_doorbell.sv
module mdu_doorbell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_bits,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] bits_q
);
  // set first, then clear: a collision on one bit leaves it clear
  function automatic logic [DW-1:0] next_bits(input logic [DW-1:0] cur,
                                              input logic se, input logic [DW-1:0] sb,
                                              input logic ce, input logic [DW-1:0] cb);
    logic [DW-1:0] t;
    t = se ? (cur | sb) : cur;
    return ce ? (t & ~cb) : t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= next_bits(bits_q, set_en, set_bits, clr_en, clr_bits);
  end
endmodule

// File: rtl/mdu_mailbox.sv
module mdu_mailbox #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] data_q,
  output logic          pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      data_q <= wr_data;
      pend_q <= 1'b1;      // a fresh message outranks a same-cycle take
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/msg_doorbell_unit.sv
module msg_doorbell_unit
  import mdu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [DW-1:0]      h_wdata,
  output logic [DW-1:0]      h_rdata,
  input  logic               l_wr,
  input  logic               l_rd,
  input  logic [LADDR_W-1:0] l_addr,
  input  logic [DW-1:0]      l_wdata,
  output logic [DW-1:0]      l_rdata,
  output logic               host_irq,
  output logic               local_irq,
  output logic               cpu0_irq,
  output logic               cpu1_irq
);
  // control state
  logic             ext_mode;
  logic [N_SRC-1:0] hmask, lmask;

  // standard-path strobes, frozen in processor-to-processor mode
  logic std_hw, std_hr, std_lw, std_lr, ext_lw;
  assign std_hw = h_wr & ~ext_mode;
  assign std_hr = h_rd & ~ext_mode;
  assign std_lw = l_wr & ~ext_mode;
  assign std_lr = l_rd & ~ext_mode;
  assign ext_lw = l_wr &  ext_mode;

  // named events
  logic idb_set_ev, idb_clr_ev, odb_set_ev, odb_clr_ev;
  logic hmask_wr_ev, lctrl_wr_ev;
  assign idb_set_ev  = std_hw && (h_addr == HA_IDB);
  assign idb_clr_ev  = std_lw && (l_addr == LA_IDB);
  assign odb_set_ev  = std_lw && (l_addr == LA_ODB);
  assign odb_clr_ev  = std_hw && (h_addr == HA_ODB);
  assign hmask_wr_ev = std_hw && (h_addr == HA_MASK);
  assign lctrl_wr_ev = l_wr   && (l_addr == LA_CTRL);

  logic [DW-1:0] idb_q, odb_q;

  mdu_doorbell #(.DW(DW)) u_idb (
    .clk(clk), .rst_n(rst_n),
    .set_en(idb_set_ev), .set_bits(h_wdata),
    .clr_en(idb_clr_ev), .clr_bits(l_wdata),
    .bits_q(idb_q)
  );

  mdu_doorbell #(.DW(DW)) u_odb (
    .clk(clk), .rst_n(rst_n),
    .set_en(odb_set_ev), .set_bits(l_wdata),
    .clr_en(odb_clr_ev), .clr_bits(h_wdata),
    .bits_q(odb_q)
  );

  // processor-to-processor doorbells: index 0 targets processor 0, 1 targets 1
  logic [DW-1:0] xdb_q [2];
  logic [1:0]    xdb_set_ev, xdb_clr_ev;
  assign xdb_set_ev[1] = ext_lw && (l_addr == LA_X1SET);
  assign xdb_clr_ev[1] = ext_lw && (l_addr == LA_X1CLR);
  assign xdb_set_ev[0] = ext_lw && (l_addr == LA_X0SET);
  assign xdb_clr_ev[0] = ext_lw && (l_addr == LA_X0CLR);

  for (genvar p = 0; p < 2; p++) begin : g_xdb
    mdu_doorbell #(.DW(DW)) u_xdb (
      .clk(clk), .rst_n(rst_n),
      .set_en(xdb_set_ev[p]), .set_bits(l_wdata),
      .clr_en(xdb_clr_ev[p]), .clr_bits(l_wdata),
      .bits_q(xdb_q[p])
    );
  end

  // message words
  logic [DW-1:0]    imsg_d [N_MSG];
  logic [DW-1:0]    omsg_d [N_MSG];
  logic [N_MSG-1:0] imsg_pend, omsg_pend;
  logic [N_MSG-1:0] imsg_wr_ev, imsg_take_ev, omsg_wr_ev, omsg_take_ev;

  for (genvar i = 0; i < N_MSG; i++) begin : g_msg
    assign imsg_wr_ev[i]   = std_hw && (h_addr == HA_IMSG + HADDR_W'(i));
    assign imsg_take_ev[i] = (std_lr && (l_addr == LA_IMSG + LADDR_W'(i)))
                           || (std_lw && (l_addr == LA_STAT) && l_wdata[1+i]);
    assign omsg_wr_ev[i]   = std_lw && (l_addr == LA_OMSG + LADDR_W'(i));
    assign omsg_take_ev[i] = (std_hr && (h_addr == HA_OMSG + HADDR_W'(i)))
                           || (std_hw && (h_addr == HA_STAT) && h_wdata[1+i]);

    mdu_mailbox #(.DW(DW)) u_imsg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(imsg_wr_ev[i]), .wr_data(h_wdata), .take(imsg_take_ev[i]),
      .data_q(imsg_d[i]), .pend_q(imsg_pend[i])
    );
    mdu_mailbox #(.DW(DW)) u_omsg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(omsg_wr_ev[i]), .wr_data(l_wdata), .take(omsg_take_ev[i]),
      .data_q(omsg_d[i]), .pend_q(omsg_pend[i])
    );
  end

  // masks and mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmask    <= '0;
      lmask    <= '0;
      ext_mode <= 1'b0;
    end else begin
      if (hmask_wr_ev) hmask <= h_wdata[N_SRC-1:0];
      if (lctrl_wr_ev) begin
        lmask    <= l_wdata[N_SRC-1:0];
        ext_mode <= l_wdata[CTRL_MODE_BIT];
      end
    end
  end

  // interrupts
  logic idb_nz, odb_nz;
  assign idb_nz    = |idb_q;
  assign odb_nz    = |odb_q;
  assign local_irq = ~ext_mode & src_irq(idb_nz, imsg_pend, lmask);
  assign host_irq  = ~ext_mode & src_irq(odb_nz, omsg_pend, hmask);
  assign cpu0_irq  =  ext_mode & (|xdb_q[0]);
  assign cpu1_irq  =  ext_mode & (|xdb_q[1]);

  // read muxes
  always_comb begin
    h_rdata = '0;
    case (h_addr)
      HA_IDB:            h_rdata = idb_q;
      HA_ODB:            h_rdata = odb_q;
      HA_IMSG:           h_rdata = imsg_d[0];
      HA_IMSG + 3'd1:    h_rdata = imsg_d[1];
      HA_OMSG:           h_rdata = omsg_d[0];
      HA_OMSG + 3'd1:    h_rdata = omsg_d[1];
      HA_STAT:           h_rdata = DW'({omsg_pend, odb_nz});
      default:           h_rdata = DW'(hmask);
    endcase
  end

  always_comb begin
    l_rdata = '0;
    case (l_addr)
      LA_IDB:            l_rdata = idb_q;
      LA_ODB:            l_rdata = odb_q;
      LA_IMSG:           l_rdata = imsg_d[0];
      LA_IMSG + 4'd1:    l_rdata = imsg_d[1];
      LA_OMSG:           l_rdata = omsg_d[0];
      LA_OMSG + 4'd1:    l_rdata = omsg_d[1];
      LA_STAT:           l_rdata = DW'({imsg_pend, idb_nz});
      LA_CTRL:           l_rdata = DW'({ext_mode, lmask});
      LA_X1RD:           l_rdata = xdb_q[1];
      LA_X0RD:           l_rdata = xdb_q[0];
      default:           l_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic [2:0]    h_addr,
  input logic          l_wr,
  input logic [3:0]    l_addr,
  input logic [DW-1:0] idb_q,
  input logic [DW-1:0] odb_q,
  input logic [1:0]    imsg_pend,
  input logic [1:0]    omsg_pend,
  input logic          ext_mode,
  input logic          host_irq,
  input logic          local_irq,
  input logic          cpu0_irq,
  input logic          cpu1_irq
);
  AST_IDB_SET_ONLY_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr && h_addr == 3'd0) |=> ((idb_q & ~$past(idb_q)) == '0)); // R2
  AST_IDB_CLR_ONLY_BY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_wr && l_addr == 4'd0) |=> ((~idb_q & $past(idb_q)) == '0)); // R3
  AST_ODB_CLR_ONLY_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr && h_addr == 3'd1) |=> ((~odb_q & $past(odb_q)) == '0)); // R4
  AST_IMSG_PEND_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imsg_pend[0]) |-> $past(h_wr && h_addr == 3'd2)); // R5
  AST_OMSG_PEND_FROM_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(omsg_pend[1]) |-> $past(l_wr && l_addr == 4'd5)); // R6
  AST_HOST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (odb_q != '0 || omsg_pend != '0)); // R7
  AST_EXT_SILENCES_STD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (!host_irq && !local_irq)); // R10
  AST_STD_SILENCES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> (!cpu0_irq && !cpu1_irq)); // R10
endmodule

bind msg_doorbell_unit mdu_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .l_wr(l_wr), .l_addr(l_addr),
  .idb_q(idb_q), .odb_q(odb_q), .imsg_pend(imsg_pend), .omsg_pend(omsg_pend),
  .ext_mode(ext_mode), .host_irq(host_irq), .local_irq(local_irq),
  .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq)
);

// File: tb/msg_doorbell_unit_tb.sv
module msg_doorbell_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [2:0]  h_addr = 0;
  logic [3:0]  l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic        host_irq, local_irq, cpu0_irq, cpu1_irq;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  msg_doorbell_unit #(.DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .host_irq(host_irq), .local_irq(local_irq), .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq)
  );

  // behavioural reference state
  bit [31:0] m_in_bell, m_out_bell, m_p2p [2];
  bit [31:0] m_in_word [2], m_out_word [2];
  bit        m_in_flag [2], m_out_flag [2];
  bit [2:0]  m_hblock, m_lblock;
  bit        m_p2p_on;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in_bell = 0; m_out_bell = 0; m_hblock = 0; m_lblock = 0; m_p2p_on = 0;
      for (int k = 0; k < 2; k++) begin
        m_p2p[k] = 0; m_in_word[k] = 0; m_out_word[k] = 0;
        m_in_flag[k] = 0; m_out_flag[k] = 0;
      end
    end else begin
      bit on; on = m_p2p_on;
      if (!on) begin
        if (h_wr && h_addr == 0) m_in_bell = m_in_bell | h_wdata;
        if (l_wr && l_addr == 0) m_in_bell = m_in_bell & ~l_wdata;
        if (l_wr && l_addr == 1) m_out_bell = m_out_bell | l_wdata;
        if (h_wr && h_addr == 1) m_out_bell = m_out_bell & ~h_wdata;
        for (int k = 0; k < 2; k++) begin
          if ((l_rd && l_addr == 2 + k) || (l_wr && l_addr == 6 && l_wdata[1+k])) m_in_flag[k] = 0;
          if (h_wr && h_addr == 2 + k) begin m_in_word[k] = h_wdata; m_in_flag[k] = 1; end
          if ((h_rd && h_addr == 4 + k) || (h_wr && h_addr == 6 && h_wdata[1+k])) m_out_flag[k] = 0;
          if (l_wr && l_addr == 4 + k) begin m_out_word[k] = l_wdata; m_out_flag[k] = 1; end
        end
        if (h_wr && h_addr == 7) m_hblock = h_wdata[2:0];
      end else if (l_wr) begin
        case (l_addr)
          8:  m_p2p[1] = m_p2p[1] | l_wdata;
          9:  m_p2p[1] = m_p2p[1] & ~l_wdata;
          10: m_p2p[0] = m_p2p[0] | l_wdata;
          11: m_p2p[0] = m_p2p[0] & ~l_wdata;
          default: ;
        endcase
      end
      if (l_wr && l_addr == 7) begin m_lblock = l_wdata[2:0]; m_p2p_on = l_wdata[3]; end
    end
  end

  function automatic bit [31:0] exp_hread(input int a);
    case (a)
      0: return m_in_bell;
      1: return m_out_bell;
      2, 3: return m_in_word[a-2];
      4, 5: return m_out_word[a-4];
      6: return {29'd0, m_out_flag[1], m_out_flag[0], m_out_bell != 0};
      default: return {29'd0, m_hblock};
    endcase
  endfunction

  function automatic bit [31:0] exp_lread(input int a);
    case (a)
      0: return m_in_bell;
      1: return m_out_bell;
      2, 3: return m_in_word[a-2];
      4, 5: return m_out_word[a-4];
      6: return {29'd0, m_in_flag[1], m_in_flag[0], m_in_bell != 0};
      7: return {28'd0, m_p2p_on, m_lblock};
      12: return m_p2p[1];
      13: return m_p2p[0];
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_lirq();
    if (m_p2p_on) return 0;
    return (m_in_bell != 0 && !m_lblock[0]) || (m_in_flag[0] && !m_lblock[1]) || (m_in_flag[1] && !m_lblock[2]);
  endfunction

  function automatic bit exp_hirq();
    if (m_p2p_on) return 0;
    return (m_out_bell != 0 && !m_hblock[0]) || (m_out_flag[0] && !m_hblock[1]) || (m_out_flag[1] && !m_hblock[2]);
  endfunction

  task automatic check(input string what, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (!done) begin
    check("h_rdata", h_rdata, exp_hread(h_addr));
    check("l_rdata", l_rdata, exp_lread(l_addr));
    check("local_irq", 32'(local_irq), 32'(exp_lirq()));
    check("host_irq", 32'(host_irq), 32'(exp_hirq()));
    check("cpu0_irq", 32'(cpu0_irq), 32'(m_p2p_on && m_p2p[0] != 0));
    check("cpu1_irq", 32'(cpu1_irq), 32'(m_p2p_on && m_p2p[1] != 0));
  end

  task automatic cyc(input bit hw, input bit hr, input int ha, input bit [31:0] hd,
                     input bit lw, input bit lr, input int la, input bit [31:0] ld);
    @(posedge clk); #1;
    h_wr = hw; h_rd = hr; h_addr = 3'(ha); h_wdata = hd;
    l_wr = lw; l_rd = lr; l_addr = 4'(la); l_wdata = ld;
  endtask
  task automatic hwr(input int a, input bit [31:0] d); cyc(1,0,a,d,0,0,0,0); endtask
  task automatic hrd(input int a);                     cyc(0,1,a,0,0,0,0,0); endtask
  task automatic lwr(input int a, input bit [31:0] d); cyc(0,0,0,0,1,0,a,d); endtask
  task automatic lrd(input int a);                     cyc(0,0,0,0,0,1,a,0); endtask
  task automatic idle(input int h, input int l);       cyc(0,0,h,0,0,0,l,0); endtask

  initial begin
    // R1: reset state on every address
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 0; a < 8; a++) idle(a, a);
    for (int a = 8; a < 16; a++) idle(0, a);

    tag = "R2";
    hwr(0, 32'h0000_0005); idle(0, 0);
    hwr(0, 32'h0000_0100); idle(0, 6);
    hwr(0, 32'h0); idle(0, 0);

    tag = "R3";
    lwr(0, 32'h0000_0004); idle(0, 0);
    lwr(0, 32'h0); idle(0, 0);
    cyc(1,0,0,32'h8000_0000, 1,0,0,32'h8000_0100); idle(0, 0);   // set/clear collision
    lwr(0, 32'h0000_0001); idle(0, 6);

    tag = "R4";
    lwr(1, 32'h0000_00f0); idle(1, 1);
    lwr(1, 32'h0000_0003); idle(1, 1);
    hwr(1, 32'h0000_0030); idle(1, 0);
    lwr(0, 32'hffff_ffff); idle(1, 1);                           // local cannot clear it
    hwr(1, 32'h0000_00c3); idle(6, 1);

    tag = "R5";
    hwr(2, 32'hdead_beef); idle(2, 6);
    lrd(2); idle(2, 6);
    hwr(3, 32'h1234_5678); idle(3, 3);
    lwr(6, 32'h0000_0002); idle(0, 6);                           // wrong bit: stays
    lwr(6, 32'h0000_0004); idle(0, 6);
    cyc(1,0,2,32'h0bad_f00d, 0,1,2,0); idle(0, 6);              // write beats read-clear
    lrd(2); idle(0, 6);

    tag = "R6";
    lwr(4, 32'hcafe_0001); idle(6, 4);
    lwr(5, 32'hcafe_0002); idle(6, 5);
    hrd(4); idle(6, 0);
    hwr(6, 32'h0000_0004); idle(6, 0);
    cyc(1,0,6,32'h2, 1,0,4,32'h0000_0077); idle(6, 0);          // write beats status clear
    hrd(4); idle(6, 0);

    tag = "R7";
    hwr(0, 32'h1); lwr(7, 32'h1); idle(0, 7);
    hwr(2, 32'h55); idle(0, 7);
    lwr(7, 32'h3); idle(0, 7);
    lwr(7, 32'h0); lrd(2); lwr(0, 32'h1); idle(0, 0);
    lwr(1, 32'h8); hwr(7, 32'h1); idle(7, 0);
    lwr(5, 32'h9); idle(7, 0);
    hwr(7, 32'h4); idle(7, 0);
    hwr(7, 32'h0); hrd(5); hwr(1, 32'h8); idle(6, 6);

    tag = "R8";
    hwr(0, 32'h2); lwr(1, 32'h2); hwr(3, 32'h3); lwr(4, 32'h4);
    idle(6, 6); lwr(7, 32'h5); idle(0, 7);
    lwr(7, 32'h0); idle(6, 6);

    tag = "R9";
    lwr(7, 32'h8); idle(0, 12);
    lwr(8, 32'h0000_0003); idle(0, 12);
    lwr(9, 32'h0000_0001); idle(0, 12);
    lwr(10, 32'h0000_0010); idle(0, 13);
    lwr(9, 32'h0000_0002); idle(0, 12);
    lwr(11, 32'h0000_0010); idle(0, 13);
    lwr(10, 32'h0000_0001); idle(0, 13);

    tag = "R10";
    hwr(0, 32'h0000_f000); idle(0, 0);
    hwr(2, 32'h7777_7777); lrd(3); idle(2, 6);
    lwr(1, 32'h0000_0f00); lwr(0, 32'hffff_ffff); idle(1, 0);
    hwr(7, 32'h7); idle(7, 0);
    lwr(7, 32'h0); idle(0, 6);                                   // pending interrupts return
    lwr(8, 32'hffff_ffff); lwr(10, 32'h1); idle(0, 12);
    idle(0, 13);

    tag = "R5";   // randomised two-port traffic, standard mode only
    for (int n = 0; n < 3000; n++) begin
      int la; la = $urandom_range(0, 6);
      cyc($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,7), $urandom,
          $urandom_range(0,1), $urandom_range(0,1), la, $urandom & 32'h0000_0f07);
    end
    idle(0, 0); idle(0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule